// File: doc/BRIEF.md
# Power Button and Reset Request Arbiter

This block sits between a debounced power-button level, three request lines from an application processor and a power state controller. It turns a held button into one of two one-cycle events: a boot event after a short hold while the system is off, and a forced power-off after a long hold in any state. It also judges the processor's shutdown requests and drives an active-low system reset output with a pulse of fixed length.

All four asynchronous inputs pass through a two-stage synchroniser. A millisecond tick input paces the hold timers and the reset pulse. A warm-reset request starts the reset pulse and marks a reboot as pending. The next shutdown-request edge is then refused and clears that mark. A shutdown request is also refused while the watchdog line is low.

Top module: `pra_top`

## Requirements
- R1: Every input passes through two flip-flops before use, and each event output is high for exactly one cycle per qualifying edge or timer expiry. After reset all events are low and `sys_rst_n` is high.
- R2: With `sys_off` high, a press held for BOOT_MS ticks raises `evt_boot` once. BOOT_MS-1 ticks are not enough.
- R3: With `sys_off` low when the boot count is reached, no `evt_boot` is raised.
- R4: A press held for FORCE_MS ticks raises `evt_force_off` once, whatever the value of `sys_off`. Further ticks while the button stays held raise nothing more.
- R5: Releasing the button clears both hold counters to zero, so a pending event is cancelled and the next press counts from the start.
- R6: A rising edge on `warm_rst_req` drives `sys_rst_n` low for PULSE_MS ticks and then back high.
- R7: A new warm-reset edge during an active pulse restarts the count at PULSE_MS.
- R8: A warm-reset edge marks a reboot as pending. The next falling edge of `shutdown_req_n` then raises no `evt_shutdown`.
- R9: A falling edge of `shutdown_req_n` with `wdog_n` high and no pending reboot raises `evt_shutdown`.
- R10: A falling edge of `shutdown_req_n` while `wdog_n` is low raises no `evt_shutdown`.
- R11: Every falling edge of `shutdown_req_n` clears the pending reboot, whether the request is accepted or refused.
- R12: A warm-reset edge and a shutdown edge in the same cycle count as a reboot. The shutdown is refused, the reset pulse starts, and the pending mark ends cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| sys_off | input | 1 | High while the system is in any off state |
| btn_level | input | 1 | Debounced power-button level, high when pressed |
| warm_rst_req | input | 1 | Warm-reset request from the processor, active high |
| shutdown_req_n | input | 1 | Shutdown request from the processor, active low |
| wdog_n | input | 1 | Processor watchdog, active low |
| evt_boot | output | 1 | One-cycle boot-from-off event |
| evt_force_off | output | 1 | One-cycle forced power-off event |
| evt_shutdown | output | 1 | One-cycle accepted shutdown-request event |
| sys_rst_n | output | 1 | System reset output, active low |

## Verification
A warm-reset edge and a shutdown-request edge can land in the same synchronised cycle. There the reboot-pending mark is set and consumed at the same moment. The bench provokes this by changing both inputs on the same clock edge. It passes when no shutdown event appears and the reset output goes low. A later lone shutdown request must then be accepted, which proves the mark was cleared and not left set.

// File: rtl/pra_pkg.sv
package pra_pkg;

    // Synchronised view of the asynchronous request inputs
    typedef struct packed {
        logic btn;
        logic warm;
        logic sd_n;
        logic wd_n;
    } req_vec_t;

    localparam int REQ_W = $bits(req_vec_t);

    // Counter width able to hold values 0..n
    function automatic int cnt_width(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/pra_sync.sv
module pra_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    input  logic [W-1:0] rst_val,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= rst_val;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= rst_val;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pra_hold_timer.sv
module pra_hold_timer #(
    parameter int BOOT_MS  = 10,
    parameter int FORCE_MS = 8000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic btn,
    input  logic sys_off,
    output logic evt_boot,
    output logic evt_force
);
    localparam int CW = pra_pkg::cnt_width(FORCE_MS);
    localparam logic [CW-1:0] BOOT_LAST  = CW'(BOOT_MS - 1);
    localparam logic [CW-1:0] FORCE_LAST = CW'(FORCE_MS - 1);
    localparam logic [CW-1:0] FORCE_TOP  = CW'(FORCE_MS);

    logic [CW-1:0] held;
    logic          step;

    assign step = btn && tick && (held != FORCE_TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            held      <= '0;
            evt_boot  <= 1'b0;
            evt_force <= 1'b0;
        end else begin
            evt_boot  <= step && (held == BOOT_LAST) && sys_off;
            evt_force <= step && (held == FORCE_LAST);
            if (!btn)      held <= '0;
            else if (step) held <= held + 1'b1;
        end
    end
endmodule

// File: rtl/pra_pulse_gen.sv
module pra_pulse_gen #(
    parameter int PULSE_MS = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic trig,
    output logic rst_n
);
    localparam int CW = pra_pkg::cnt_width(PULSE_MS);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_MS);

    logic [CW-1:0] left, left_nx;

    always_comb begin
        left_nx = left;
        if (trig)                    left_nx = LOAD;
        else if (tick && left != 0)  left_nx = left - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            left  <= '0;
            rst_n <= 1'b1;
        end else begin
            left  <= left_nx;
            rst_n <= (left_nx == '0);
        end
    end
endmodule

// File: rtl/pra_req_filter.sv
module pra_req_filter (
    input  logic clk,
    input  logic rst,
    input  logic warm_edge,
    input  logic sd_edge,
    input  logic wd_ok,
    output logic evt_shutdown
);
    logic reboot_pend;
    logic pend_eff;

    // A warm edge in the same cycle counts as already pending
    assign pend_eff = reboot_pend || warm_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            reboot_pend  <= 1'b0;
            evt_shutdown <= 1'b0;
        end else begin
            evt_shutdown <= sd_edge && wd_ok && !pend_eff;
            if (sd_edge)        reboot_pend <= 1'b0;
            else if (warm_edge) reboot_pend <= 1'b1;
        end
    end
endmodule

// File: rtl/pra_top.sv
module pra_top #(
    parameter int BOOT_MS     = 10,
    parameter int FORCE_MS    = 8000,
    parameter int PULSE_MS    = 30,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ms_tick,
    input  logic sys_off,
    input  logic btn_level,
    input  logic warm_rst_req,
    input  logic shutdown_req_n,
    input  logic wdog_n,
    output logic evt_boot,
    output logic evt_force_off,
    output logic evt_shutdown,
    output logic sys_rst_n
);
    import pra_pkg::*;

    req_vec_t raw_req, idle_req, req_s, req_prev;
    logic     warm_edge, sd_edge, wd_ok, btn_s;

    assign raw_req  = '{btn: btn_level, warm: warm_rst_req, sd_n: shutdown_req_n, wd_n: wdog_n};
    assign idle_req = '{btn: 1'b0, warm: 1'b0, sd_n: 1'b1, wd_n: 1'b1};

    pra_sync #(.W(REQ_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(raw_req), .rst_val(idle_req), .q(req_s)
    );

    always_ff @(posedge clk) begin
        if (rst) req_prev <= idle_req;
        else     req_prev <= req_s;
    end

    assign warm_edge = req_s.warm && !req_prev.warm;
    assign sd_edge   = !req_s.sd_n && req_prev.sd_n;
    assign wd_ok     = req_s.wd_n;
    assign btn_s     = req_s.btn;

    pra_hold_timer #(.BOOT_MS(BOOT_MS), .FORCE_MS(FORCE_MS)) u_hold (
        .clk(clk), .rst(rst), .tick(ms_tick), .btn(btn_s), .sys_off(sys_off),
        .evt_boot(evt_boot), .evt_force(evt_force_off)
    );

    pra_pulse_gen #(.PULSE_MS(PULSE_MS)) u_pulse (
        .clk(clk), .rst(rst), .tick(ms_tick), .trig(warm_edge), .rst_n(sys_rst_n)
    );

    pra_req_filter u_filt (
        .clk(clk), .rst(rst), .warm_edge(warm_edge), .sd_edge(sd_edge),
        .wd_ok(wd_ok), .evt_shutdown(evt_shutdown)
    );
endmodule

// File: rtl/pra_checker.sv
module pra_checker (
    input logic clk,
    input logic rst,
    input logic ms_tick,
    input logic sys_off,
    input logic btn_s,
    input logic warm_edge,
    input logic sd_edge,
    input logic wd_ok,
    input logic evt_boot,
    input logic evt_force_off,
    input logic evt_shutdown,
    input logic sys_rst_n
);
    // R3: boot only while the system reports off
    p_boot_when_off_r3: assert property (@(posedge clk) disable iff (rst)
        evt_boot |-> $past(sys_off));

    // R5: a released button raises no hold event on the next cycle
    p_release_cancels_r5: assert property (@(posedge clk) disable iff (rst)
        !btn_s |=> !evt_boot && !evt_force_off);

    // R4: a forced power-off needs the button held
    p_force_needs_btn_r4: assert property (@(posedge clk) disable iff (rst)
        evt_force_off |-> $past(btn_s));

    // R6: a warm-reset edge pulls the reset output low
    p_warm_drives_low_r6: assert property (@(posedge clk) disable iff (rst)
        warm_edge |=> !sys_rst_n);

    // R6: the reset output only releases on a tick
    p_release_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_n) |-> $past(ms_tick));

    // R10: no accepted shutdown while the watchdog is low
    p_wdog_blocks_r10: assert property (@(posedge clk) disable iff (rst)
        evt_shutdown |-> $past(wd_ok) && $past(sd_edge));

    // R12: a same-cycle warm edge refuses the shutdown
    p_same_cycle_r12: assert property (@(posedge clk) disable iff (rst)
        (warm_edge && sd_edge) |=> !evt_shutdown);

    // R1: events last a single cycle
    p_single_cycle_r1: assert property (@(posedge clk) disable iff (rst)
        evt_shutdown |=> !evt_shutdown);
endmodule

bind pra_top pra_checker u_chk (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .sys_off(sys_off), .btn_s(btn_s),
    .warm_edge(warm_edge), .sd_edge(sd_edge), .wd_ok(wd_ok),
    .evt_boot(evt_boot), .evt_force_off(evt_force_off),
    .evt_shutdown(evt_shutdown), .sys_rst_n(sys_rst_n)
);

// File: tb/tb_pra_top.sv
module tb_pra_top;
    localparam int BOOT  = 3;
    localparam int FORCE = 8;
    localparam int PULSE = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ms_tick = 1'b0, sys_off = 1'b1, btn_level = 1'b0;
    logic warm_rst_req = 1'b0, shutdown_req_n = 1'b1, wdog_n = 1'b1;
    logic evt_boot, evt_force_off, evt_shutdown, sys_rst_n;

    int n_run = 0, n_fail = 0;
    int c_boot = 0, c_force = 0, c_sd = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pra_top #(.BOOT_MS(BOOT), .FORCE_MS(FORCE), .PULSE_MS(PULSE)) dut (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .sys_off(sys_off),
        .btn_level(btn_level), .warm_rst_req(warm_rst_req),
        .shutdown_req_n(shutdown_req_n), .wdog_n(wdog_n),
        .evt_boot(evt_boot), .evt_force_off(evt_force_off),
        .evt_shutdown(evt_shutdown), .sys_rst_n(sys_rst_n)
    );

    // Count every high cycle of each event, sampled away from the edge
    always @(negedge clk) begin
        if (!rst) begin
            if (evt_boot)      c_boot++;
            if (evt_force_off) c_force++;
            if (evt_shutdown)  c_sd++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk) ms_tick = 1'b1;
            @(negedge clk) ms_tick = 1'b0;
        end
        idle(3);
    endtask

    task automatic shut_pulse();
        @(negedge clk) shutdown_req_n = 1'b0;
        idle(5);
        shutdown_req_n = 1'b1;
        idle(5);
    endtask

    task automatic warm_pulse();
        @(negedge clk) warm_rst_req = 1'b1;
        idle(5);
        warm_rst_req = 1'b0;
        idle(5);
    endtask

    // Shutdown table: {warm before, wdog_n, accepted}
    localparam logic [2:0] SD_TAB [7] = '{
        3'b011, 3'b110, 3'b011, 3'b000, 3'b011, 3'b100, 3'b011
    };

    initial begin
        int base;
        idle(4);
        rst = 1'b0;
        idle(1);
        check("R1 reset evt_boot", evt_boot, 0);
        check("R1 reset evt_force_off", evt_force_off, 0);
        check("R1 reset evt_shutdown", evt_shutdown, 0);
        check("R1 reset sys_rst_n", sys_rst_n, 1);

        // Table walk: shutdown acceptance (R8, R9, R10, R11)
        for (int i = 0; i < 7; i++) begin
            base = c_sd;
            if (SD_TAB[i][2]) warm_pulse();
            wdog_n = SD_TAB[i][1];
            idle(4);
            shut_pulse();
            wdog_n = 1'b1;
            idle(4);
            check($sformatf("R8 R9 R10 R11 row %0d", i), c_sd - base, int'(SD_TAB[i][0]));
        end
        ticks(PULSE);
        check("R6 reset released after table", sys_rst_n, 1);

        // R2 and R4: boot and forced off while off
        sys_off = 1'b1;
        @(negedge clk) btn_level = 1'b1;
        idle(4);
        ticks(BOOT - 1);
        check("R2 no boot one tick short", c_boot, 0);
        ticks(1);
        check("R2 boot after hold", c_boot, 1);
        ticks(FORCE - BOOT - 1);
        check("R4 no force one tick short", c_force, 0);
        ticks(1);
        check("R4 force after long hold", c_force, 1);
        ticks(3);
        check("R4 force once per press", c_force, 1);
        check("R2 boot once per press", c_boot, 1);
        @(negedge clk) btn_level = 1'b0;
        idle(4);

        // R5: release restarts the count
        btn_level = 1'b1;
        idle(4);
        ticks(BOOT - 1);
        btn_level = 1'b0;
        idle(4);
        btn_level = 1'b1;
        idle(4);
        ticks(BOOT - 1);
        check("R5 count restarts after release", c_boot, 1);
        ticks(1);
        check("R5 boot after fresh hold", c_boot, 2);
        ticks(FORCE - BOOT - 2);
        btn_level = 1'b0;
        idle(4);
        ticks(3);
        check("R5 release cancels force", c_force, 1);

        // R3 and R4: system on
        sys_off = 1'b0;
        btn_level = 1'b1;
        idle(4);
        ticks(FORCE);
        check("R3 no boot while on", c_boot, 2);
        check("R4 force while on", c_force, 2);
        btn_level = 1'b0;
        idle(4);

        // R6: pulse length
        warm_pulse();
        check("R6 low after warm edge", sys_rst_n, 0);
        ticks(PULSE - 1);
        check("R6 still low one tick short", sys_rst_n, 0);
        ticks(1);
        check("R6 high after pulse", sys_rst_n, 1);

        // R7: retrigger restarts
        warm_pulse();
        ticks(3);
        warm_pulse();
        ticks(PULSE - 1);
        check("R7 retrigger keeps low", sys_rst_n, 0);
        ticks(1);
        check("R7 high after restarted pulse", sys_rst_n, 1);
        shut_pulse(); // consume pending reboot

        // R12: same-cycle warm and shutdown edges
        base = c_sd;
        @(negedge clk) begin
            warm_rst_req = 1'b1;
            shutdown_req_n = 1'b0;
        end
        idle(6);
        check("R12 simultaneous refused", c_sd - base, 0);
        check("R12 reset pulse started", sys_rst_n, 0);
        warm_rst_req = 1'b0;
        shutdown_req_n = 1'b1;
        idle(5);
        ticks(PULSE);
        shut_pulse();
        check("R12 mark cleared, next accepted", c_sd - base, 1);
        check("R1 events single cycle", c_sd - base, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule